// File: doc/BRIEF.md
# Mode-Configurable Byte SPI Master

This block is a single-target SPI master that exchanges one byte per transfer: eight bits leave on the serial data output, most significant bit first, while eight bits are gathered from the serial data input. A system-side agent sets the serial clock polarity, the clock phase and a half-period divisor, places the outgoing byte on a parallel input and pulses start. The block asserts its active-low select, produces exactly eight serial clock pulses, and then releases select while pulsing done with the received byte.

All four polarity/phase combinations are supported. With phase 0 the first bit is on the data line at the moment select falls, further bits change as the clock returns to rest and the input is sampled as the clock leaves rest. With phase 1 every bit, the first one included, is launched as the clock leaves rest and sampled as it returns. Everything runs from one system clock. Each serial clock half-period lasts a programmable number of system cycles.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, select is high, the serial clock is low, the data output is 0, and busy and done are 0.
- R2: While no transfer is in progress, the serial clock rests at the level of the polarity input (one cycle of register delay). During a transfer, its rest level is the polarity captured at start.
- R3: A transfer produces exactly 8 clock pulses. Every clock edge, including the first one measured from the fall of select, is spaced div+1 system cycles from the one before it.
- R4: A start seen while busy is 0 is accepted. On the next clock edge select goes low and busy goes high. Busy stays high exactly while select is low.
- R5: With phase 0, bit 7 of the transmit byte is on the data output in the cycle select falls. The receiver sees all 8 bits MSB-first when it samples at the clock's leaving-rest edges.
- R6: With phase 1, the data output changes on leaving-rest edges. A receiver sampling on returning-to-rest edges sees the transmit byte MSB-first.
- R7: The received byte is assembled MSB-first from the data input. It is sampled on leaving-rest edges in phase 0 and on returning-to-rest edges in phase 1.
- R8: Done is high for exactly one cycle and the received byte is valid in that cycle. Select rises and busy falls on the same clock edge, div+1 system cycles after the last serial clock edge.
- R9: Start is ignored while busy is high. No second transfer begins, and only one done pulse follows.
- R10: Changes of polarity, phase, divisor or transmit byte while busy do not affect the running transfer.
- R11: While idle, the data output holds the last bit sent, whatever the transmit byte input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a transfer (taken when busy is low) |
| cpol_i | input | 1 | Clock rest level: 0 low, 1 high |
| cpha_i | input | 1 | Phase: 0 first bit at select, 1 first bit at first edge |
| div_i | input | DIV_W | Half-period length minus one, in system cycles |
| tx_data_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | DATA_W | Received byte, valid with done |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to target |
| ss_n_o | output | 1 | Active-low target select |
| miso_i | input | 1 | Serial data from target |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=4, so the all-ones divisor of 15 can be reached along with the fastest setting of 0. The longest transfer then stays under three hundred cycles. A model of the target follows the captured mode to drive and sample bits. Its timestamps of every clock edge give exact half-period and select-release spacing for divisors 0, 1, 2, 3 and 15 across all four modes.

// File: rtl/spi_mstr_pkg.sv
package spi_mstr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } xfer_state_t;

  // Edges are numbered from 1; odd numbers leave the rest level.
  function automatic logic edge_leaves_rest(input int unsigned idx);
    return idx[0];
  endfunction

  // Sampling edge: leaving rest in phase 0, returning to rest in phase 1.
  function automatic logic edge_samples(input logic cpha, input int unsigned idx);
    return cpha ? !edge_leaves_rest(idx) : edge_leaves_rest(idx);
  endfunction

  // Launch edge: the opposite of sampling, except that phase 0 launches
  // nothing on the final edge (its first bit went out with select).
  function automatic logic edge_launches(input logic cpha, input int unsigned idx,
                                         input int unsigned total);
    if (cpha) return edge_leaves_rest(idx);
    return !edge_leaves_rest(idx) && (idx != total);
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || tick || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_mstr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick,
  output logic             accept,
  output logic             run,
  output logic [DIV_W-1:0] div_cap,
  output logic             cpol_cap,
  output logic             cpha_cap,
  output logic             edge_ev,
  output logic             sample_ev,
  output logic             launch_ev,
  output logic             finish_ev,
  output logic             busy_o,
  output logic             ss_n_o,
  output logic             done_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(EDGES - 1);

  xfer_state_t      state;
  logic [CW-1:0]    edge_cnt;
  int unsigned      edge_idx;

  assign accept    = start_i && (state == ST_IDLE);
  assign run       = (state != ST_IDLE);
  assign edge_ev   = tick && (state == ST_RUN);
  assign finish_ev = tick && (state == ST_TAIL);
  assign edge_idx  = int'(edge_cnt) + 1;
  assign sample_ev = edge_ev && edge_samples(cpha_cap, edge_idx);
  assign launch_ev = edge_ev && edge_launches(cpha_cap, edge_idx, EDGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      div_cap  <= '0;
      cpol_cap <= 1'b0;
      cpha_cap <= 1'b0;
      busy_o   <= 1'b0;
      ss_n_o   <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            edge_cnt <= '0;
            div_cap  <= div_i;
            cpol_cap <= cpol_i;
            cpha_cap <= cpha_i;
            busy_o   <= 1'b1;
            ss_n_o   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == LAST_CNT) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
            ss_n_o <= 1'b1;
            done_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sclk_drv.sv
module spi_sclk_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic cpol_i,
  input  logic edge_ev,
  output logic sclk_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o <= 1'b0;
    end else if (idle) begin
      sclk_o <= cpol_i;
    end else if (edge_ev) begin
      sclk_o <= ~sclk_o;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cpha_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              launch_ev,
  input  logic              sample_ev,
  input  logic              finish_ev,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      mosi_o    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      if (load) begin
        rx_sh <= '0;
        if (cpha_i) begin
          tx_sh <= tx_data_i;
        end else begin
          mosi_o <= tx_data_i[MSB];
          tx_sh  <= tx_data_i << 1;
        end
      end else begin
        if (launch_ev) begin
          mosi_o <= tx_sh[MSB];
          tx_sh  <= tx_sh << 1;
        end
        if (sample_ev) rx_sh <= {rx_sh[MSB-1:0], miso_i};
      end
      if (finish_ev) rx_data_o <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_n_o,
  input  logic              miso_i
);
  logic             accept;
  logic             run;
  logic             tick;
  logic [DIV_W-1:0] div_cap;
  logic             cpol_cap;
  logic             cpha_cap;
  logic             edge_ev;
  logic             sample_ev;
  logic             launch_ev;
  logic             finish_ev;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clear (accept),
    .limit (div_cap),
    .tick  (tick)
  );

  spi_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cpol_i    (cpol_i),
    .cpha_i    (cpha_i),
    .div_i     (div_i),
    .tick      (tick),
    .accept    (accept),
    .run       (run),
    .div_cap   (div_cap),
    .cpol_cap  (cpol_cap),
    .cpha_cap  (cpha_cap),
    .edge_ev   (edge_ev),
    .sample_ev (sample_ev),
    .launch_ev (launch_ev),
    .finish_ev (finish_ev),
    .busy_o    (busy_o),
    .ss_n_o    (ss_n_o),
    .done_o    (done_o)
  );

  spi_sclk_drv u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (!busy_o),
    .cpol_i  (cpol_i),
    .edge_ev (edge_ev),
    .sclk_o  (sclk_o)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cpha_i    (cpha_i),
    .tx_data_i (tx_data_i),
    .launch_ev (launch_ev),
    .sample_ev (sample_ev),
    .finish_ev (finish_ev),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_data_o (rx_data_o)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic ss_n_o,
  input logic cpol_cap,
  input logic cpha_cap,
  input logic edge_ev
);
  // R8: done never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: select only rises together with done
  a_r8_ss_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n_o) |-> done_o);

  // R4: busy mirrors select
  a_r4_busy_is_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == !ss_n_o);

  // R3: inside a transfer the clock toggles only on a timed edge event
  a_r3_sclk_timed: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n_o && $past(!ss_n_o) && (sclk_o != $past(sclk_o))) |-> $past(edge_ev));

  // R10: captured mode is frozen while busy
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(cpol_cap) && $stable(cpha_cap)));

  // R11: data output holds while idle
  a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && !$rose(busy_o)) |-> $stable(mosi_o));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .ss_n_o   (ss_n_o),
  .cpol_cap (cpol_cap),
  .cpha_cap (cpha_cap),
  .edge_ev  (edge_ev)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  localparam int DW = 8;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cpol_i = 1'b0;
  logic          cpha_i = 1'b0;
  logic [VW-1:0] div_i = '0;
  logic [DW-1:0] tx_data_i = '0;
  logic          busy_o, done_o, sclk_o, mosi_o, ss_n_o;
  logic [DW-1:0] rx_data_o;
  logic          miso_i = 1'b0;

  spi_byte_master #(.DATA_W(DW), .DIV_W(VW)) u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .div_i(div_i), .tx_data_i(tx_data_i),
    .busy_o(busy_o), .done_o(done_o), .rx_data_o(rx_data_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .miso_i(miso_i)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model
  logic [DW-1:0] s_byte, s_tx, s_rx;
  logic s_cpol = 1'b0, s_cpha = 1'b0, s_lead;
  int   s_div = 0, s_pulses = 0, prev_cyc = 0, last_edge_cyc = 0;
  bit   hp_bad = 0;

  always @(negedge ss_n_o) begin
    #1;
    s_tx = s_byte; s_rx = '0; s_pulses = 0; hp_bad = 0; prev_cyc = cyc;
    if (!s_cpha) begin miso_i = s_tx[DW-1]; s_tx = s_tx << 1; end
  end

  always @(sclk_o) if (ss_n_o === 1'b0) begin
    #1;
    s_lead = (sclk_o != s_cpol);
    if (cyc - prev_cyc != s_div + 1) hp_bad = 1;
    prev_cyc = cyc; last_edge_cyc = cyc;
    if (s_lead) s_pulses++;
    if (s_lead == !s_cpha) s_rx = {s_rx[DW-2:0], mosi_o};
    else begin miso_i = s_tx[DW-1]; s_tx = s_tx << 1; end
  end

  // scoreboard
  typedef struct { logic [DW-1:0] mrx; logic [DW-1:0] srx; logic cpha; int div; } exp_t;
  exp_t q[$];
  bit prev_done = 0;

  always @(negedge clk) if (rst_n) begin
    if (prev_done) chk(done_o == 1'b0, "R8 done width", done_o, 0);
    if (done_o) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rx_data_o == e.mrx, "R7 rx byte", rx_data_o, e.mrx);
        chk(s_rx == e.srx, e.cpha ? "R6 target byte" : "R5 target byte", s_rx, e.srx);
        chk(s_pulses == 8, "R3 pulse count", s_pulses, 8);
        chk(!hp_bad, "R3 half-period", hp_bad, 0);
        chk(cyc - last_edge_cyc == e.div + 1, "R8 select tail", cyc - last_edge_cyc, e.div + 1);
        chk(ss_n_o && !busy_o, "R8 select/busy release", {ss_n_o, busy_o}, 2);
      end
    end
    prev_done = done_o;
  end

  task automatic xfer(input bit pol, input bit pha, input int dv,
                      input logic [DW-1:0] tx, input logic [DW-1:0] srx, input bit meddle);
    exp_t e;
    @(negedge clk);
    cpol_i = pol; cpha_i = pha; div_i = VW'(dv); tx_data_i = tx;
    s_cpol = pol; s_cpha = pha; s_div = dv; s_byte = srx;
    repeat (2) @(negedge clk);
    chk(sclk_o == pol, "R2 idle level", sclk_o, pol);
    e.mrx = srx; e.srx = tx; e.cpha = pha; e.div = dv;
    q.push_back(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !ss_n_o, "R4 start accepted", {busy_o, ss_n_o}, 2);
    if (!pha) chk(mosi_o == tx[DW-1], "R5 first bit at select", mosi_o, tx[DW-1]);
    if (meddle) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1; tx_data_i = ~tx; cpol_i = ~pol; cpha_i = ~pha; div_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      chk(sclk_o != cpol_i || busy_o, "R10 still running", busy_o, 1);
    end
    do @(negedge clk); while (busy_o);
    repeat (4) @(negedge clk);
    if (meddle) chk(ss_n_o && !busy_o, "R9 no second transfer", {ss_n_o, busy_o}, 2);
    tx_data_i = ~tx_data_i;
    repeat (3) @(negedge clk);
    chk(mosi_o == tx[0], "R11 data holds", mosi_o, tx[0]);
    chk(sclk_o == cpol_i, "R2 rest after transfer", sclk_o, cpol_i);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(ss_n_o && !sclk_o && !mosi_o && !busy_o && !done_o, "R1 reset state",
        {ss_n_o, sclk_o, mosi_o, busy_o, done_o}, 5'b10000);
    rst_n = 1'b1;
    xfer(0, 0, 0, 8'hA5, 8'h3C, 0);
    xfer(0, 1, 1, 8'h81, 8'h7E, 0);
    xfer(1, 0, 2, 8'hC3, 8'h96, 0);
    xfer(1, 1, 3, 8'hFF, 8'h01, 1);
    xfer(0, 0, 15, 8'h5A, 8'hA5, 0);
    xfer(1, 1, 0, 8'h36, 8'hE4, 1);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", wd, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule